// File: doc/BRIEF.md
# Register-Configured Pad Function Multiplexer

This block sits between a row of IO pads and the peripherals that want to use them. Each pad may be claimed by one of several functions that belong to that pad, and a small selection register per pad decides which function owns it. The owning function drives the pad's output value and its output-enable, so the pad's direction moves together with its data, and it alone receives the pad's input. Every other function attached to the pad sees a constant zero on its input.

Software reaches the selection registers through a plain register port: a single-cycle write strobe with address and data, and a combinational read path that returns data together with an error flag. The register index is a bit slice of the address. An index that names no pad is refused with the error flag raised, and the stored state is left alone. The select lines are driven straight from the registers on every cycle, so a write changes the routing from the clock edge that stores it.

Top module: `pad_mux_top`

## Requirements
- R1: On reset every selection register holds 0, so pad k is owned by its function 0 (bit k*NUM_FUNCS of the function vectors) and every read of a valid index returns 0.
- R2: For each pad k with selection value s, `pad_out[k]` equals `fn_out[k*NUM_FUNCS+s]` and `pad_oe[k]` equals `fn_oe[k*NUM_FUNCS+s]`. Output and enable follow the same selection.
- R3: `fn_in[k*NUM_FUNCS+s]` equals `pad_in[k]` for the selected function s. Every other `fn_in` bit of pad k is 0.
- R4: A write with `wr_en`=1 and index `wr_addr[4:2]` below NUM_PADS stores `wr_data[1:0]` into that pad's register and discards the higher data bits. The new routing is visible from the cycle after the clock edge that performs the write.
- R5: A write whose index `wr_addr[4:2]` is NUM_PADS or more raises `wr_err` in the same cycle and changes no register. `wr_err` is 0 whenever `wr_en` is 0.
- R6: A read with index `rd_addr[4:2]` below NUM_PADS returns that register zero-extended to 32 bits with `rd_err`=0. A higher index returns `rd_data`=0 with `rd_err`=1.
- R7: A read that falls in the same cycle as a write to the same register returns the value held before the write.
- R8: Address bits outside `[4:2]` have no effect on which register a write or read uses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selection registers |
| wr_addr | input | 32 | Write address; index in bits [4:2] |
| wr_data | input | 32 | Write data; low 2 bits are stored |
| wr_err | output | 1 | Write refused because of an invalid index |
| rd_addr | input | 32 | Read address; index in bits [4:2] |
| rd_data | output | 32 | Read data, zero-extended selection value |
| rd_err | output | 1 | Read refused because of an invalid index |
| fn_out | input | 16 | Output value from each function, pad k function f at bit k*4+f |
| fn_oe | input | 16 | Output-enable from each function, same bit layout |
| fn_in | output | 16 | Pad input delivered to each function, same bit layout |
| pad_in | input | 4 | Value seen on each pad |
| pad_out | output | 4 | Value driven onto each pad |
| pad_oe | output | 4 | Output-enable for each pad |

## Verification
The register write and the register read can fall in the same cycle, and a write can also land while the pad fabric is carrying live traffic whose routing it is about to change. The bench provokes both by pairing a write and a read of the same index in one cycle, and by issuing writes under random function and pad stimulus. A behavioural reference model that updates its selection table only at the clock edge judges the read data as the old value and the pad routing as switching one cycle later.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

    parameter int PM_NUM_PADS  = 4;
    parameter int PM_NUM_FUNCS = 4;
    parameter int PM_ADDR_W    = 32;
    parameter int PM_DATA_W    = 32;
    parameter int PM_IDX_HI    = 4;
    parameter int PM_IDX_LO    = 2;

    // One pad's drive pair: value and direction travel together
    typedef struct packed {
        logic oe;
        logic val;
    } pad_drive_t;

    localparam pad_drive_t PAD_IDLE = '{oe: 1'b0, val: 1'b0};

endpackage

// File: rtl/pm_sel_bank.sv
module pm_sel_bank #(
    parameter int NUM_PADS = 4,
    parameter int SEL_W    = 2,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_HI   = 4,
    parameter int IDX_LO   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      wr_err,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_err,
    output logic [NUM_PADS*SEL_W-1:0] sel_flat
);
    localparam int IDX_W = IDX_HI - IDX_LO + 1;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_hit_any;
    logic             rd_hit_any;
    logic [SEL_W-1:0] sel_q [NUM_PADS];
    logic             unused_bits;

    assign wr_idx      = wr_addr[IDX_HI:IDX_LO];
    assign rd_idx      = rd_addr[IDX_HI:IDX_LO];
    assign wr_hit_any  = int'(wr_idx) < NUM_PADS;
    assign rd_hit_any  = int'(rd_idx) < NUM_PADS;
    assign wr_err      = wr_en & ~wr_hit_any;
    assign unused_bits = ^{wr_addr, rd_addr, wr_data};

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[p] <= '0;
            end else if (wr_en && int'(wr_idx) == p) begin
                sel_q[p] <= wr_data[SEL_W-1:0];
            end
        end
        assign sel_flat[p*SEL_W +: SEL_W] = sel_q[p];
    end

    always_comb begin
        rd_data = '0;
        rd_err  = ~rd_hit_any;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (int'(rd_idx) == p) begin
                rd_data = DATA_W'(sel_q[p]);
            end
        end
    end

endmodule

// File: rtl/pm_pad_lane.sv
module pm_pad_lane
    import pad_mux_pkg::*;
#(
    parameter int NUM_FUNCS = 4,
    parameter int SEL_W     = 2
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    output logic [NUM_FUNCS-1:0] fn_in,
    input  logic                 pad_in,
    output pad_drive_t           drive
);
    logic [NUM_FUNCS-1:0] hit;

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
        assign hit[f]   = (sel == SEL_W'(f));
        assign fn_in[f] = hit[f] & pad_in;
    end

    // Codes with no function behind them leave the pad at the zero source
    always_comb begin
        drive = PAD_IDLE;
        for (int f = 0; f < NUM_FUNCS; f++) begin
            if (hit[f]) begin
                drive.val = fn_out[f];
                drive.oe  = fn_oe[f];
            end
        end
    end

endmodule

// File: rtl/pad_mux_top.sv
module pad_mux_top
    import pad_mux_pkg::*;
#(
    parameter int NUM_PADS  = PM_NUM_PADS,
    parameter int NUM_FUNCS = PM_NUM_FUNCS,
    parameter int ADDR_W    = PM_ADDR_W,
    parameter int DATA_W    = PM_DATA_W,
    parameter int IDX_HI    = PM_IDX_HI,
    parameter int IDX_LO    = PM_IDX_LO,
    localparam int SEL_W    = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
    localparam int FN_W     = NUM_PADS * NUM_FUNCS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_err,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_err,
    input  logic [FN_W-1:0]     fn_out,
    input  logic [FN_W-1:0]     fn_oe,
    output logic [FN_W-1:0]     fn_in,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);
    logic [NUM_PADS*SEL_W-1:0] sel_flat;

    pm_sel_bank #(
        .NUM_PADS (NUM_PADS),
        .SEL_W    (SEL_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_HI   (IDX_HI),
        .IDX_LO   (IDX_LO)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_err   (wr_err),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .sel_flat (sel_flat)
    );

    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
        pad_drive_t drv;

        pm_pad_lane #(
            .NUM_FUNCS (NUM_FUNCS),
            .SEL_W     (SEL_W)
        ) u_lane (
            .sel    (sel_flat[k*SEL_W +: SEL_W]),
            .fn_out (fn_out[k*NUM_FUNCS +: NUM_FUNCS]),
            .fn_oe  (fn_oe[k*NUM_FUNCS +: NUM_FUNCS]),
            .fn_in  (fn_in[k*NUM_FUNCS +: NUM_FUNCS]),
            .pad_in (pad_in[k]),
            .drive  (drv)
        );

        assign pad_out[k] = drv.val;
        assign pad_oe[k]  = drv.oe;
    end

endmodule

// File: rtl/pad_mux_chk.sv
module pad_mux_chk #(
    parameter int NUM_PADS  = 4,
    parameter int NUM_FUNCS = 4,
    parameter int SEL_W     = 2,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int IDX_HI    = 4,
    parameter int IDX_LO    = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [DATA_W-1:0]             rd_data,
    input logic                          rd_err,
    input logic [NUM_PADS*NUM_FUNCS-1:0] fn_in,
    input logic [NUM_PADS*SEL_W-1:0]     sel_flat
);
    // R1
    sel_reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_flat == '0));

    // R5
    bad_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr[IDX_HI:IDX_LO]) >= NUM_PADS) |=> $stable(sel_flat));

    // R6
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == '0));

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
        // R4
        write_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && int'(wr_addr[IDX_HI:IDX_LO]) == p)
            |=> (sel_flat[p*SEL_W +: SEL_W] == $past(wr_data[SEL_W-1:0])));

        // R3
        one_input_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(fn_in[p*NUM_FUNCS +: NUM_FUNCS]));
    end

endmodule

bind pad_mux_top pad_mux_chk #(
    .NUM_PADS  (NUM_PADS),
    .NUM_FUNCS (NUM_FUNCS),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_HI    (IDX_HI),
    .IDX_LO    (IDX_LO)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .fn_in    (fn_in),
    .sel_flat (sel_flat)
);

// File: tb/pad_mux_top_tb.sv
module pad_mux_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic [31:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_err;
    logic [15:0] fn_out = '0;
    logic [15:0] fn_oe = '0;
    logic [15:0] fn_in;
    logic [3:0]  pad_in = '0;
    logic [3:0]  pad_out;
    logic [3:0]  pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int sel_m [4];

    always #2 clk = ~clk;

    pad_mux_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_err(wr_err), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_err(rd_err), .fn_out(fn_out),
        .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [3:0]  e_out, e_oe;
        logic [15:0] e_in;
        logic [31:0] e_rd;
        logic        e_rerr;
        int          ridx;
        e_in = '0;
        for (int k = 0; k < 4; k++) begin
            e_out[k] = fn_out[k*4 + sel_m[k]];
            e_oe[k]  = fn_oe[k*4 + sel_m[k]];
            e_in[k*4 + sel_m[k]] = pad_in[k];
        end
        ridx = int'(rd_addr[4:2]);
        e_rd   = (ridx < 4) ? 32'(sel_m[ridx]) : 32'd0;
        e_rerr = (ridx >= 4);
        check(pad_out == e_out, {"R2 pad_out ", tag}, 32'(pad_out), 32'(e_out));
        check(pad_oe == e_oe, {"R2 pad_oe ", tag}, 32'(pad_oe), 32'(e_oe));
        check(fn_in == e_in, {"R3 fn_in ", tag}, 32'(fn_in), 32'(e_in));
        check(wr_err == (wr_en && int'(wr_addr[4:2]) >= 4), {"R5 wr_err ", tag},
              32'(wr_err), 32'(wr_en && int'(wr_addr[4:2]) >= 4));
        check(rd_data == e_rd, {"R6 rd_data ", tag}, rd_data, e_rd);
        check(rd_err == e_rerr, {"R6 rd_err ", tag}, 32'(rd_err), 32'(e_rerr));
    endtask

    // One cycle: drive at the falling edge, compare, update the model at the rising edge
    task automatic step(input bit we, input logic [31:0] wa, input logic [31:0] wd,
                        input logic [31:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        fn_out = 16'($urandom); fn_oe = 16'($urandom); pad_in = 4'($urandom);
        #1 compare_all(tag);
        @(posedge clk);
        if (we && int'(wa[4:2]) < 4) sel_m[int'(wa[4:2])] = int'(wd[1:0]);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) sel_m[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: every pad owned by function 0 after reset
        for (int k = 0; k < 4; k++) step(1'b0, '0, '0, 32'(k) << 2, "R1 reset");

        // R4: write each pad, upper data bits dropped, read back next cycle
        for (int k = 0; k < 4; k++)
            step(1'b1, 32'(k) << 2, 32'hFFFF_FFF0 | 32'(3 - k), 32'(k) << 2, "R4 write");
        for (int k = 0; k < 4; k++) begin
            step(1'b0, '0, '0, 32'(k) << 2, "R4 readback");
            check(rd_data == 32'(3 - k), "R4 stored value", rd_data, 32'(3 - k));
        end

        // R5: invalid indices refused, state unchanged
        for (int i = 4; i < 8; i++) step(1'b1, 32'(i) << 2, 32'h1, 32'(i) << 2, "R5 bad write");
        for (int k = 0; k < 4; k++) begin
            step(1'b0, '0, '0, 32'(k) << 2, "R5 unchanged");
            check(rd_data == 32'(3 - k), "R5 register kept", rd_data, 32'(3 - k));
        end

        // R7: read and write same register in one cycle returns old value
        step(1'b1, 32'h4, 32'h0, 32'h4, "R7 same cycle");
        check(rd_data == 32'd2, "R7 old value", rd_data, 32'd2);
        step(1'b0, '0, '0, 32'h4, "R7 after");
        check(rd_data == 32'd0, "R7 new value", rd_data, 32'd0);

        // R8: bits outside [4:2] ignored
        step(1'b1, 32'hABC0_0003 | (32'd2 << 2), 32'h1, 32'h1230_0002 | (32'd2 << 2), "R8 write");
        step(1'b0, '0, '0, 32'hFFFF_FFE3 & ~32'h10 | (32'd2 << 2), "R8 read");
        check(rd_data == 32'd1 && !rd_err, "R8 alias", rd_data, 32'd1);

        // Random traffic with writes and reads mixed in
        for (int c = 0; c < 3000; c++)
            step(1'($urandom), $urandom, $urandom, $urandom, "random");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule